// File: doc/BRIEF.md
# Eye Window Centering Accumulator

This block condenses the edge-search results of one byte lane into a single sampling point. A training run is opened with a start pulse. The run then feeds one result set per training pattern. Each set holds eight per-bit start taps, eight per-bit end taps, and two lock flags, one from each search direction. The block keeps a lane-wide window that only shrinks: its left edge is the latest start seen so far and its right edge is the earliest end seen so far. After every pattern it checks that window against a minimum-width rule and a boundary exception.

When the end-of-patterns pulse arrives, the block classifies the lane. The status code is 0 for a clean lock, 1 for a failure, 2 for a narrow window pinned at the top tap and 3 for a narrow window pinned at tap 0. For a passing lane it reports the centre tap and the window length. It also merges the low five bits of that length into a caller-supplied result word, at a field position chosen by the transfer direction. In write mode every tap value carries a constant offset, which is removed again when the centre is computed.

Top module: `eye_center_acc`

## Requirements
- R1: A start pulse sets the accumulated start to 0, the accumulated end to MAX_WIN-1 plus the mode offset, the internal status to 0, and clears `fail_o`. A run with no patterns therefore ends with status 0, and in read mode with the default MAX_WIN=32 it gives centre 15 and length 32. After reset, all outputs are 0.
- R2: The mode offset is WR_OFF (64) when `wr_mode_i`=1 at start, and 0 otherwise. The centre is ((end+start) taken at 9 bits, shifted right by one) minus the offset, kept modulo 256. The window length is end-start+1, also modulo 256.
- R3: Each accepted pattern sets start to max(old start, largest bit start) and end to min(old end, smallest bit end). Bit k occupies bits [8k+7:8k] of `starts_i` and of `ends_i`.
- R4: A pattern with either lock flag low is ignored when the status is already 1. Otherwise each bit whose start is nonzero and whose end is 0 has its end replaced by MAX_WIN-1. Any other bit sets the status to 1 and the whole pattern is discarded without raising `fail_o`.
- R5: After each accumulation, the window is valid if any one of three conditions holds. The first is that (end+1) exceeds (start+MIN_WIN) and (end+1) is below (start+MAX_WIN), all in 8-bit arithmetic. The second is start==0 with end!=0. The third is start!=MAX_WIN-1 with end==MAX_WIN-1. An invalid window sets the status to 1 and raises the sticky `fail_o`.
- R6: At the end of the run, a lane whose status is not 1 and whose d=end-start satisfies 2<d<MIN_WIN gets status 2 if end==MAX_WIN-1, or status 3 if end==0.
- R7: Statuses 0, 2 and 3 set `ok_o`=1 and report the centre and length. Status 1 gives `ok_o`=0, centre 0 and length 0, and passes `word_i` through unchanged to `word_o`.
- R8: On success, `word_o` is `word_i` with bits [RD_LSB+4:RD_LSB] (read, default 0) or [WR_LSB+4:WR_LSB] (write, default 8) replaced by the low five bits of the length. All other bits are kept.
- R9: `done_o` is high for exactly one cycle, the cycle after `last_i` is sampled, with all results valid in that cycle. A pattern presented in the same cycle as `last_i` is not accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a run and latches the mode |
| wr_mode_i | input | 1 | 1 = write direction, 0 = read direction |
| pat_valid_i | input | 1 | One pattern result set is present |
| starts_i | input | NBITS*TW | Per-bit start taps |
| ends_i | input | NBITS*TW | Per-bit end taps |
| lock_lh_i | input | 1 | Low-to-high search locked |
| lock_hl_i | input | 1 | High-to-low search locked |
| last_i | input | 1 | End-of-patterns pulse |
| word_i | input | RW | Result word to merge the length into |
| done_o | output | 1 | One-cycle result strobe |
| status_o | output | 2 | Lane status code 0..3 |
| ok_o | output | 1 | Lane produced a result |
| centre_o | output | TW | Centre tap |
| win_len_o | output | TW | Window length |
| word_o | output | RW | Merged result word |
| fail_o | output | 1 | Sticky window-validity failure |

## Verification
The bench sweeps every start/end pair of a single locked pattern over the 32-tap range. This covers the validity edges at the minimum width, the exceptions at tap 0 and the top tap, and the narrow-at-top status 2. A wrong comparison bound or a missing exception would misclassify specific pairs. Directed runs cover the following: repair of unlocked bits versus discarding the pattern, and ignoring a pattern after failure, which a faulty design would expose by raising `fail_o`; the write offset, where a missing offset would give centre 47 instead of 239; field placement in the word; and a pattern sent together with `last_i`, which a faulty design would fold into the result.

// File: rtl/eye_pkg.sv
package eye_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_FAIL    = 2'd1,
    ST_EDGE_HI = 2'd2,
    ST_EDGE_LO = 2'd3
  } lane_st_t;
endpackage

// File: rtl/eye_lane_reduce.sv
module eye_lane_reduce #(
  parameter int TW      = 8,
  parameter int NBITS   = 8,
  parameter int MAX_WIN = 32
) (
  input  logic [NBITS*TW-1:0] starts_i,
  input  logic [NBITS*TW-1:0] ends_i,
  input  logic                fix_i,
  output logic [TW-1:0]       max_s_o,
  output logic [TW-1:0]       min_e_o,
  output logic                bad_o
);
  localparam logic [TW-1:0] TOP = TW'(MAX_WIN - 1);

  logic [NBITS-1:0][TW-1:0] eff_e;
  logic [NBITS-1:0][TW-1:0] bit_s;
  logic [NBITS-1:0]         bad_b;

  for (genvar g = 0; g < NBITS; g++) begin : g_bit
    logic fixable;
    assign bit_s[g] = starts_i[g*TW +: TW];
    assign fixable  = (bit_s[g] != '0) && (ends_i[g*TW +: TW] == '0);
    assign eff_e[g] = (fix_i && fixable) ? TOP : ends_i[g*TW +: TW];
    assign bad_b[g] = fix_i && !fixable;
  end

  always_comb begin
    max_s_o = '0;
    min_e_o = '1;
    for (int i = 0; i < NBITS; i++) begin
      if (bit_s[i] > max_s_o) max_s_o = bit_s[i];
      if (eff_e[i] < min_e_o) min_e_o = eff_e[i];
    end
    bad_o = |bad_b;
  end
endmodule

// File: rtl/eye_window_check.sv
module eye_window_check #(
  parameter int TW      = 8,
  parameter int MAX_WIN = 32,
  parameter int MIN_WIN = 10
) (
  input  logic [TW-1:0] s_i,
  input  logic [TW-1:0] e_i,
  output logic          valid_o
);
  localparam logic [TW-1:0] TOP = TW'(MAX_WIN - 1);

  logic [TW-1:0] e_inc, s_min, s_max;
  logic wide_ok, edge_lo, edge_hi;

  always_comb begin
    e_inc   = e_i + TW'(1);
    s_min   = s_i + TW'(MIN_WIN);
    s_max   = s_i + TW'(MAX_WIN);
    wide_ok = (e_inc > s_min) && (e_inc < s_max);
    edge_lo = (s_i == '0) && (e_i != '0);
    edge_hi = (s_i != TOP) && (e_i == TOP);
    valid_o = wide_ok || edge_lo || edge_hi;
  end
endmodule

// File: rtl/eye_finalize.sv
module eye_finalize
  import eye_pkg::*;
#(
  parameter int TW      = 8,
  parameter int MAX_WIN = 32,
  parameter int MIN_WIN = 10,
  parameter int WR_OFF  = 64
) (
  input  logic [TW-1:0] s_i,
  input  logic [TW-1:0] e_i,
  input  lane_st_t      st_i,
  input  logic          wr_i,
  output lane_st_t      st_o,
  output logic          ok_o,
  output logic [TW-1:0] centre_o,
  output logic [TW-1:0] len_o
);
  localparam logic [TW-1:0] TOP = TW'(MAX_WIN - 1);

  logic [TW-1:0] d, off;
  logic [TW:0]   sum;
  logic          narrow;

  always_comb begin
    d      = e_i - s_i;
    narrow = (d > TW'(2)) && (d < TW'(MIN_WIN));
    st_o   = st_i;
    if (st_i != ST_FAIL) begin
      if ((e_i == TOP) && narrow) st_o = ST_EDGE_HI;
      if ((e_i == '0) && narrow)  st_o = ST_EDGE_LO;
    end
    ok_o     = (st_o != ST_FAIL);
    off      = wr_i ? TW'(WR_OFF) : '0;
    sum      = {1'b0, e_i} + {1'b0, s_i};
    centre_o = ok_o ? (sum[TW:1] - off) : '0;
    len_o    = ok_o ? (d + TW'(1)) : '0;
  end
endmodule

// File: rtl/eye_center_acc.sv
module eye_center_acc
  import eye_pkg::*;
#(
  parameter int TW      = 8,
  parameter int NBITS   = 8,
  parameter int MAX_WIN = 32,
  parameter int MIN_WIN = 10,
  parameter int WR_OFF  = 64,
  parameter int RW      = 16,
  parameter int RD_LSB  = 0,
  parameter int WR_LSB  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                wr_mode_i,
  input  logic                pat_valid_i,
  input  logic [NBITS*TW-1:0] starts_i,
  input  logic [NBITS*TW-1:0] ends_i,
  input  logic                lock_lh_i,
  input  logic                lock_hl_i,
  input  logic                last_i,
  input  logic [RW-1:0]       word_i,
  output logic                done_o,
  output logic [1:0]          status_o,
  output logic                ok_o,
  output logic [TW-1:0]       centre_o,
  output logic [TW-1:0]       win_len_o,
  output logic [RW-1:0]       word_o,
  output logic                fail_o
);
  localparam int            FW    = 5;
  localparam logic [RW-1:0] FMASK = RW'((1 << FW) - 1);
  localparam logic [TW-1:0] E_RD  = TW'(MAX_WIN - 1);
  localparam logic [TW-1:0] E_WR  = TW'(MAX_WIN - 1 + WR_OFF);

  logic [TW-1:0] acc_s, acc_e;
  lane_st_t      st_q;
  logic          mode_q;

  logic          unlocked;
  logic [TW-1:0] pat_s, pat_e, nxt_s, nxt_e;
  logic          pat_bad, win_ok;

  assign unlocked = !(lock_lh_i && lock_hl_i);

  eye_lane_reduce #(.TW(TW), .NBITS(NBITS), .MAX_WIN(MAX_WIN)) u_reduce (
    .starts_i (starts_i),
    .ends_i   (ends_i),
    .fix_i    (unlocked),
    .max_s_o  (pat_s),
    .min_e_o  (pat_e),
    .bad_o    (pat_bad)
  );

  assign nxt_s = (pat_s > acc_s) ? pat_s : acc_s;
  assign nxt_e = (pat_e < acc_e) ? pat_e : acc_e;

  eye_window_check #(.TW(TW), .MAX_WIN(MAX_WIN), .MIN_WIN(MIN_WIN)) u_check (
    .s_i     (nxt_s),
    .e_i     (nxt_e),
    .valid_o (win_ok)
  );

  lane_st_t      fin_st;
  logic          fin_ok;
  logic [TW-1:0] fin_centre, fin_len;
  logic [RW-1:0] merged;

  eye_finalize #(.TW(TW), .MAX_WIN(MAX_WIN), .MIN_WIN(MIN_WIN), .WR_OFF(WR_OFF)) u_fin (
    .s_i      (acc_s),
    .e_i      (acc_e),
    .st_i     (st_q),
    .wr_i     (mode_q),
    .st_o     (fin_st),
    .ok_o     (fin_ok),
    .centre_o (fin_centre),
    .len_o    (fin_len)
  );

  always_comb begin
    if (!fin_ok)
      merged = word_i;
    else if (mode_q)
      merged = (word_i & ~(FMASK << WR_LSB)) | (RW'(fin_len[FW-1:0]) << WR_LSB);
    else
      merged = (word_i & ~(FMASK << RD_LSB)) | (RW'(fin_len[FW-1:0]) << RD_LSB);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_s     <= '0;
      acc_e     <= E_RD;
      st_q      <= ST_OK;
      mode_q    <= 1'b0;
      fail_o    <= 1'b0;
      done_o    <= 1'b0;
      status_o  <= '0;
      ok_o      <= 1'b0;
      centre_o  <= '0;
      win_len_o <= '0;
      word_o    <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        acc_s  <= '0;
        acc_e  <= wr_mode_i ? E_WR : E_RD;
        st_q   <= ST_OK;
        mode_q <= wr_mode_i;
        fail_o <= 1'b0;
      end else if (last_i) begin
        done_o    <= 1'b1;
        status_o  <= fin_st;
        ok_o      <= fin_ok;
        centre_o  <= fin_centre;
        win_len_o <= fin_len;
        word_o    <= merged;
      end else if (pat_valid_i) begin
        if (unlocked && (st_q == ST_FAIL)) begin
          // discarded: lane already failed and this pattern did not lock
        end else if (pat_bad) begin
          st_q <= ST_FAIL;
        end else begin
          acc_s <= nxt_s;
          acc_e <= nxt_e;
          if (!win_ok) begin
            st_q   <= ST_FAIL;
            fail_o <= 1'b1;
          end
        end
      end
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r9_done_follows_last: assert property (@(posedge clk) disable iff (rst)
    (last_i && !start_i) |=> done_o);
  a_r3_start_never_drops: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> (acc_s >= $past(acc_s)));
  a_r3_end_never_grows: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> (acc_e <= $past(acc_e)));
  a_r1_start_init: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (acc_s == '0 && st_q == ST_OK && !fail_o));
  a_r5_fail_marks_lane: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> (st_q == ST_FAIL));
  a_r4_run_status_binary: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OK) || (st_q == ST_FAIL));
  a_r7_failed_no_centre: assert property (@(posedge clk) disable iff (rst)
    (done_o && status_o == 2'd1) |-> (!ok_o && centre_o == '0 && win_len_o == '0));
endmodule

// File: tb/tb_eye_center_acc.sv
module tb_eye_center_acc;
  localparam int TW = 8, NB = 8, MAXW = 32, MINW = 10, OFF = 64, RW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, wr_mode_i = 0, pat_valid_i = 0, lock_lh_i = 1, lock_hl_i = 1, last_i = 0;
  logic [NB*TW-1:0] starts_i = '0, ends_i = '0;
  logic [RW-1:0] word_i = '0;
  logic done_o, ok_o, fail_o;
  logic [1:0] status_o;
  logic [TW-1:0] centre_o, win_len_o;
  logic [RW-1:0] word_o;

  int checks = 0, errors = 0;
  int m_s, m_e, m_st, m_wr;
  bit m_fail;
  int ps[NB];
  int pe[NB];

  always #2.5 clk = ~clk;

  eye_center_acc dut (
    .clk(clk), .rst(rst), .start_i(start_i), .wr_mode_i(wr_mode_i),
    .pat_valid_i(pat_valid_i), .starts_i(starts_i), .ends_i(ends_i),
    .lock_lh_i(lock_lh_i), .lock_hl_i(lock_hl_i), .last_i(last_i),
    .word_i(word_i), .done_o(done_o), .status_o(status_o), .ok_o(ok_o),
    .centre_o(centre_o), .win_len_o(win_len_o), .word_o(word_o), .fail_o(fail_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit win_valid(input int s, input int e);
    int a, b, c;
    a = (e + 1) & 255; b = (s + MINW) & 255; c = (s + MAXW) & 255;
    return (a > b && a < c) || (s == 0 && e != 0) || (s != MAXW - 1 && e == MAXW - 1);
  endfunction

  task automatic begin_run(input int wr);
    @(negedge clk);
    start_i = 1; wr_mode_i = wr[0];
    @(negedge clk);
    start_i = 0;
    m_s = 0; m_e = MAXW - 1 + (wr ? OFF : 0); m_st = 0; m_fail = 0; m_wr = wr;
  endtask

  task automatic fill(input int s, input int e);
    for (int k = 0; k < NB; k++) begin ps[k] = s; pe[k] = e; end
  endtask

  task automatic pat(input bit lh, input bit hl);
    bit unl, bad;
    int mx, mn, ee;
    unl = !(lh && hl); bad = 0; mx = 0; mn = 255;
    if (!(unl && m_st == 1)) begin
      for (int k = 0; k < NB; k++) begin
        ee = pe[k];
        if (unl) begin
          if (ps[k] > 0 && pe[k] == 0) ee = MAXW - 1; else bad = 1;
        end
        if (ps[k] > mx) mx = ps[k];
        if (ee < mn) mn = ee;
      end
      if (bad) m_st = 1;
      else begin
        if (mx > m_s) m_s = mx;
        if (mn < m_e) m_e = mn;
        if (!win_valid(m_s, m_e)) begin m_st = 1; m_fail = 1; end
      end
    end
    @(negedge clk);
    for (int k = 0; k < NB; k++) begin
      starts_i[k*TW +: TW] = TW'(ps[k]); ends_i[k*TW +: TW] = TW'(pe[k]);
    end
    lock_lh_i = lh; lock_hl_i = hl; pat_valid_i = 1;
    @(negedge clk);
    pat_valid_i = 0; lock_lh_i = 1; lock_hl_i = 1;
  endtask

  task automatic finish_run(input string tag, input int w);
    int st, d, cen, len, ok, ew, pos;
    word_i = RW'(w);
    @(negedge clk); last_i = 1;
    @(negedge clk); last_i = 0;
    st = m_st;
    if (st != 1) begin
      d = (m_e - m_s) & 255;
      if (m_e == MAXW - 1 && d > 2 && d < MINW) st = 2;
      if (m_e == 0 && d > 2 && d < MINW) st = 3;
    end
    ok = (st != 1);
    cen = ok ? ((((m_e + m_s) >> 1) - (m_wr ? OFF : 0)) & 255) : 0;
    len = ok ? ((m_e - m_s + 1) & 255) : 0;
    pos = m_wr ? 8 : 0;
    ew = ok ? ((w & ~(31 << pos)) | ((len & 31) << pos)) & 16'hFFFF : w;
    chk({tag, " done"}, done_o, 1);
    chk({tag, " status"}, status_o, st);
    chk({tag, " ok"}, ok_o, ok);
    chk({tag, " centre"}, centre_o, cen);
    chk({tag, " len"}, win_len_o, len);
    chk({tag, " word"}, word_o, ew);
    chk({tag, " fail flag"}, fail_o, m_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset done", done_o, 0);
    chk("R1 reset status", status_o, 0);
    chk("R1 reset centre", centre_o, 0);
    chk("R1 reset fail", fail_o, 0);

    // R1 R2 empty runs, both modes
    begin_run(0); finish_run("R1 empty read", 16'h0000);
    chk("R1 centre 15", centre_o, 15);
    begin_run(1); finish_run("R2 empty write", 16'h0000);
    chk("R2 write centre 239", centre_o, 239);
    // R9 one-cycle strobe
    @(negedge clk); chk("R9 done drops", done_o, 0);

    // R3 intersection over varied bits
    begin_run(0);
    ps = '{3, 5, 2, 4, 1, 0, 6, 2}; pe = '{28, 27, 29, 30, 26, 28, 29, 27}; pat(1, 1);
    ps = '{7, 1, 2, 0, 3, 4, 5, 2}; pe = '{30, 29, 31, 28, 29, 30, 27, 29}; pat(1, 1);
    finish_run("R3 two patterns", 16'h1234);
    chk("R3 centre 16", centre_o, 16);

    // R3 R8 write mode, field at bits 12:8
    begin_run(1);
    ps = '{2, 4, 3, 1, 0, 5, 2, 3}; pe = '{26, 25, 27, 28, 24, 26, 25, 27}; pat(1, 1);
    finish_run("R8 write field", 16'hA5A5);

    // R4 unlocked but repairable bits
    begin_run(0); fill(4, 0); ps[2] = 6; pat(0, 1);
    finish_run("R4 repaired", 16'hFFFF);

    // R4 R7 unlocked with a bad bit: fail without fail_o
    begin_run(0); fill(4, 0); ps[5] = 0; pat(1, 0);
    finish_run("R7 bad bit", 16'hBEEF);

    // R4 ignored after failure: a pattern that would raise fail_o must not
    begin_run(0); fill(3, 0); ps[0] = 0; pat(0, 0);
    fill(31, 0); pat(0, 1);
    @(negedge clk); chk("R4 ignored after fail", fail_o, 0);
    finish_run("R4 ignored", 16'h0F0F);
    // R5 same pattern with clean status is accepted and invalid
    begin_run(0); fill(31, 0); pat(0, 1);
    @(negedge clk); chk("R5 fail raised", fail_o, 1);
    finish_run("R5 top only", 16'h0000);

    // R6 narrow at top tap, R8 read field
    begin_run(0); fill(25, 31); pat(1, 1);
    finish_run("R6 edge hi", 16'hFFFF);
    chk("R6 status 2", status_o, 2);
    chk("R8 word FFE7", word_o, 16'hFFE7);

    // R9 pattern alongside last_i is not accumulated
    begin_run(0);
    @(negedge clk);
    fill(25, 31);
    for (int k = 0; k < NB; k++) begin
      starts_i[k*TW +: TW] = 8'd25; ends_i[k*TW +: TW] = 8'd31;
    end
    pat_valid_i = 1; last_i = 1; word_i = '0;
    @(negedge clk); pat_valid_i = 0; last_i = 0;
    chk("R9 done with last", done_o, 1);
    chk("R9 pattern not taken status", status_o, 0);
    chk("R9 pattern not taken len", win_len_o, 32);

    // R5 R6 R2 sweep of a single locked pattern
    for (int s = 0; s < MAXW; s++) begin
      for (int e = 0; e < MAXW; e++) begin
        begin_run(0); fill(s, e); pat(1, 1);
        finish_run("R5 sweep", 16'h5A5A);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule